// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block forms the word that a flash array returns on a read while an embedded program or erase is running, while an erase has failed, or while a block erase is suspended. From the controller's operation code, the suspend flag, the erase-started flag, the block being read, the masks of blocks being erased and of blocks that failed, and bit 7 of the data being written, it builds a status word. That word carries a polling bit, two toggle bits, an error bit and an erase-timer bit. It also drives an active-low ready/busy output.

A read is marked by a one-cycle read strobe. Both toggle flip-flops change state at the clock edge that ends a strobe cycle, so each read returns the complement of the previous one. One toggle flips on every status read. The other flips only for blocks under erase, or, after an erase failure, only for the faulty blocks. When no operation and no error are pending, or when a suspended erase is read at a block that is not being erased, the array word passes straight through. There is no data stream here: every pin is a plain level or a strobe, so no valid/ready handshake and no back-pressure apply.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle bits read 0, the error bit reads 0 and `rdy_busy_n` is 1. With `op_mode` = 0 (idle), `rd_data` equals `arr_data`.
- R2: The operation code is 0 idle, 1 program, 2 block erase, 3 chip erase. Bit 7 of a status word is the inverse of `prog_bit7` during a program. It is 0 during an erase, and 1 when a suspended erase is read at an erasing block.
- R3: Bit 6 of the status word inverts after every strobed status read while program or erase is active and not suspended. It holds its value while suspended.
- R4: Bit 5 becomes 1 one cycle after `fail` is high with a non-idle operation. It stays 1, and status keeps being returned even if `op_mode` drops to 0, until `clr_err` is seen. `clr_err` wins over a simultaneous `fail`.
- R5: Bit 3 is 1 for chip erase. For block erase it follows `erase_run`, so it is 0 while blocks are still being selected. During a program it is 0.
- R6: Bit 2 inverts after a strobed read of a block whose `erase_mask` bit is set, or of any block in chip erase, including during suspend. A strobed read of a block that is not erasing leaves it unchanged.
- R7: While the error bit is set, bit 2 inverts only on strobed reads of blocks whose `fault_mask` bit is set.
- R8: During a suspended block erase, a read of a block that is not being erased returns `arr_data` unchanged, and neither toggle bit changes.
- R9: `rdy_busy_n` is 0 while a program or erase is active and not suspended, error state included. It is 1 in idle and in a suspended block erase.
- R10: In a status word, bits 15..8, 4, 1 and 0 are 0. During a program, bit 2 reads 0 and does not invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | Controller operation: 0 idle, 1 program, 2 block erase, 3 chip erase |
| suspend | input | 1 | Block erase is suspended |
| erase_run | input | 1 | Block selection window closed, erasing started |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| fail | input | 1 | Controller reports a failed operation (pulse) |
| clr_err | input | 1 | Reset command seen: clear the error |
| rd_stb | input | 1 | One-cycle marker of a completed read |
| rd_blk | input | BLK_W | Block index of the read address |
| erase_mask | input | NBLK | Blocks selected for erase |
| fault_mask | input | NBLK | Blocks that failed to erase |
| arr_data | input | DW | Array word at the read address |
| rd_data | output | DW | Word returned to the reader |
| rdy_busy_n | output | 1 | Low while busy |

## Verification
`rd_data` and `rdy_busy_n` are combinational in the inputs and the stored bits. The bench therefore drives inputs on a falling edge and samples 1 ns later, in the same cycle. Toggle bits and the error bit are registered, so their new value is due one rising edge after the strobe, `fail` or `clr_err` cycle. The bench releases the pulse at the next falling edge and samples just after it. A sweep covers every operation, suspend and erase-started setting, every block and both programmed bit values. Its expected values come from a bench-side model of the two toggles and the error flag, which is updated only when a strobe or pulse is issued.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_BERASE = 2'd2,
    OP_CERASE = 2'd3
  } fs_op_e;
endpackage

// File: rtl/fs_err_track.sv
module fs_err_track
  import flash_status_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  fs_op_e cur_op,
  input  logic   fail,
  input  logic   clr,
  output logic   err_q,
  output fs_op_e eff_op
);
  fs_op_e err_op_q;
  logic   set_err;

  assign set_err = fail && (cur_op != OP_IDLE) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      err_op_q <= OP_IDLE;
    end else if (clr) begin
      err_q <= 1'b0;
    end else if (set_err && !err_q) begin
      err_q    <= 1'b1;
      err_op_q <= cur_op;
    end
  end

  assign eff_op = err_q ? err_op_q : cur_op;

  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_q);
  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && cur_op != OP_IDLE && !clr) |=> err_q);
  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr) |=> err_q);
endmodule

// File: rtl/fs_toggle.sv
module fs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (flip) q <= ~q;
  end

  // R3 R6
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (q != $past(q)));
  // R8
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flip |=> $stable(q));
endmodule

// File: rtl/fs_format.sv
module fs_format
  import flash_status_pkg::*;
#(
  parameter int NBLK  = 7,
  parameter int DW    = 16,
  parameter int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  fs_op_e            eff_op,
  input  logic              err,
  input  logic              suspend,
  input  logic              erase_run,
  input  logic              prog_bit7,
  input  logic              rd_stb,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [NBLK-1:0]   erase_mask,
  input  logic [NBLK-1:0]   fault_mask,
  input  logic [DW-1:0]     arr_data,
  input  logic              t6,
  input  logic              t2,
  output logic [DW-1:0]     rd_data,
  output logic              busy_n,
  output logic              stat_sel,
  output logic              flip6,
  output logic              flip2
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NBLK - 1);

  logic active, blk_ok, erasing, faulty, susp_eff, is_prog;
  logic [7:0] sbyte;

  always_comb begin
    active   = (eff_op != OP_IDLE);
    is_prog  = (eff_op == OP_PROG);
    blk_ok   = (rd_blk <= LAST_BLK);
    erasing  = blk_ok && ((eff_op == OP_CERASE) || erase_mask[rd_blk]);
    faulty   = blk_ok && fault_mask[rd_blk];
    susp_eff = suspend && (eff_op == OP_BERASE);
    stat_sel = active && !(susp_eff && !erasing);

    sbyte    = '0;
    sbyte[7] = is_prog ? ~prog_bit7 : susp_eff;
    sbyte[6] = t6;
    sbyte[5] = err;
    sbyte[3] = (eff_op == OP_CERASE) || ((eff_op == OP_BERASE) && erase_run);
    sbyte[2] = is_prog ? 1'b0 : t2;

    rd_data  = stat_sel ? {{(DW-8){1'b0}}, sbyte} : arr_data;
    busy_n   = !(active && !susp_eff);

    flip6    = rd_stb && stat_sel && !susp_eff;
    flip2    = rd_stb && stat_sel && !is_prog && (err ? faulty : erasing);
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int NBLK  = 7,
  parameter int DW    = 16,
  parameter int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              suspend,
  input  logic              erase_run,
  input  logic              prog_bit7,
  input  logic              fail,
  input  logic              clr_err,
  input  logic              rd_stb,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [NBLK-1:0]   erase_mask,
  input  logic [NBLK-1:0]   fault_mask,
  input  logic [DW-1:0]     arr_data,
  output logic [DW-1:0]     rd_data,
  output logic              rdy_busy_n
);
  fs_op_e cur_op, eff_op;
  logic   err_q, t6, t2, flip6, flip2, stat_sel;

  assign cur_op = fs_op_e'(op_mode);

  fs_err_track u_err (
    .clk(clk), .rst_n(rst_n), .cur_op(cur_op), .fail(fail),
    .clr(clr_err), .err_q(err_q), .eff_op(eff_op)
  );

  fs_toggle u_tgl6 (.clk(clk), .rst_n(rst_n), .flip(flip6), .q(t6));
  fs_toggle u_tgl2 (.clk(clk), .rst_n(rst_n), .flip(flip2), .q(t2));

  fs_format #(.NBLK(NBLK), .DW(DW), .BLK_W(BLK_W)) u_fmt (
    .eff_op(eff_op), .err(err_q), .suspend(suspend), .erase_run(erase_run),
    .prog_bit7(prog_bit7), .rd_stb(rd_stb), .rd_blk(rd_blk),
    .erase_mask(erase_mask), .fault_mask(fault_mask), .arr_data(arr_data),
    .t6(t6), .t2(t2), .rd_data(rd_data), .busy_n(rdy_busy_n),
    .stat_sel(stat_sel), .flip6(flip6), .flip2(flip2)
  );

  // R9
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && op_mode != 2'd0 && !(suspend && op_mode == 2'd2)) |-> !rdy_busy_n);
  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_busy_n |-> (rd_data[DW-1:8] == '0 && rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));
  // R2
  poll_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && op_mode == 2'd1) |-> (rd_data[7] == !prog_bit7));
  // R3
  t6_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && eff_op == OP_BERASE) |=> $stable(t6));
  // R8
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_sel |-> (rd_data == arr_data));
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int NBLK = 7;
  localparam int DW = 16;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_mode = 0;
  logic suspend = 0, erase_run = 0, prog_bit7 = 0, fail = 0, clr_err = 0, rd_stb = 0;
  logic [BW-1:0] rd_blk = 0;
  logic [NBLK-1:0] erase_mask = 0, fault_mask = 0;
  logic [DW-1:0] arr_data = 0;
  logic [DW-1:0] rd_data;
  logic rdy_busy_n;

  int total = 0, bad = 0;
  logic m6 = 0, m2 = 0, me = 0;
  logic [1:0] meo = 0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.NBLK(NBLK), .DW(DW), .BLK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .suspend(suspend),
    .erase_run(erase_run), .prog_bit7(prog_bit7), .fail(fail), .clr_err(clr_err),
    .rd_stb(rd_stb), .rd_blk(rd_blk), .erase_mask(erase_mask),
    .fault_mask(fault_mask), .arr_data(arr_data), .rd_data(rd_data),
    .rdy_busy_n(rdy_busy_n)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] eff();
    return me ? meo : op_mode;
  endfunction
  function automatic logic susp_e();
    return suspend && eff() == 2'd2;
  endfunction
  function automatic logic ers();
    return eff() == 2'd3 || erase_mask[rd_blk];
  endfunction
  function automatic logic sts();
    return eff() != 2'd0 && !(susp_e() && !ers());
  endfunction

  task automatic check_now();
    logic [1:0] e;
    e = eff();
    if (!sts()) begin
      chk("R8 passthrough", rd_data, arr_data);
    end else begin
      chk("R2 bit7", {15'd0, rd_data[7]},
          {15'd0, (e == 2'd1) ? ~prog_bit7 : susp_e()});
      chk("R3 bit6", {15'd0, rd_data[6]}, {15'd0, m6});
      chk("R4 bit5", {15'd0, rd_data[5]}, {15'd0, me});
      chk("R5 bit3", {15'd0, rd_data[3]},
          {15'd0, (e == 2'd3) || (e == 2'd2 && erase_run)});
      chk(me ? "R7 bit2" : "R6 bit2", {15'd0, rd_data[2]},
          {15'd0, (e == 2'd1) ? 1'b0 : m2});
      chk("R10 spare", {rd_data[15:8], 3'b0, rd_data[4], 2'b0, rd_data[1:0]}, 16'h0);
    end
    chk("R9 busy", {15'd0, rdy_busy_n}, {15'd0, !(e != 2'd0 && !susp_e())});
  endtask

  task automatic do_read();
    @(negedge clk);
    if (sts() && !susp_e()) m6 = ~m6;
    if (sts() && eff() != 2'd1 && (me ? fault_mask[rd_blk] : ers())) m2 = ~m2;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    #1;
    check_now();
  endtask

  task automatic pulse(input logic f, input logic c);
    @(negedge clk);
    if (c) me = 1'b0;
    else if (f && op_mode != 2'd0 && !me) begin me = 1'b1; meo = op_mode; end
    fail = f; clr_err = c;
    @(negedge clk);
    fail = 1'b0; clr_err = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    arr_data = 16'h5AC3;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 data", rd_data, 16'h5AC3);
    chk("R1 busy", {15'd0, rdy_busy_n}, 16'd1);
    rst_n = 1'b1;
    // R1 toggles start at 0: seen in first block-erase status
    @(negedge clk); op_mode = 2'd2; rd_blk = 0; erase_mask = 7'b0010110; #1;
    chk("R1 toggles", {14'd0, rd_data[6], rd_data[2]}, 16'd0);

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 2; r++)
          for (int p = 0; p < 2; p++)
            for (int b = 0; b < NBLK; b++) begin
              @(negedge clk);
              op_mode = 2'(m); suspend = s[0]; erase_run = r[0]; prog_bit7 = p[0];
              rd_blk = BW'(b); arr_data = 16'hA500 ^ 16'(b * 37 + m);
              #1;
              check_now();
              do_read();
            end

    // R4 R7: block erase failure, faulty block 2 only
    @(negedge clk);
    op_mode = 2'd2; suspend = 0; erase_run = 1; erase_mask = 7'b0001110; fault_mask = 7'b0000100;
    pulse(1'b1, 1'b0);
    check_now();
    op_mode = 2'd0;   // R4: status persists with controller idle
    for (int b = 0; b < NBLK; b++) begin
      @(negedge clk); rd_blk = BW'(b); #1;
      check_now();
      do_read();
      do_read();
    end
    // R4 second fail does not disturb; clear wins over simultaneous fail
    op_mode = 2'd1;
    pulse(1'b1, 1'b1);
    check_now();
    chk("R4 cleared", {15'd0, rd_data[5]}, 16'd0);
    // R4 fail ignored while idle
    op_mode = 2'd0;
    pulse(1'b1, 1'b0);
    check_now();
    // program failure, then read with mode idle
    op_mode = 2'd1; prog_bit7 = 1;
    pulse(1'b1, 1'b0);
    op_mode = 2'd0;
    for (int b = 0; b < NBLK; b++) begin
      @(negedge clk); rd_blk = BW'(b); #1;
      do_read();
    end
    pulse(1'b0, 1'b1);
    check_now();
    // R8 suspended erase, non-erasing blocks, repeated reads
    op_mode = 2'd2; suspend = 1; erase_mask = 7'b1000001;
    for (int b = 0; b < NBLK; b++) begin
      @(negedge clk); rd_blk = BW'(b); arr_data = 16'h0F0F + 16'(b); #1;
      do_read();
      do_read();
    end
    // R6 out-of-range block index behaves as non-erasing
    suspend = 0;
    @(negedge clk); rd_blk = 3'd7; #1;
    do_read();
    do_read();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule